// File: doc/BRIEF.md
# Receive FIFO Interrupt Controller

This block sits beside the receive FIFO of a serial port and turns FIFO state into an interrupt request for the host. It watches how many characters the FIFO holds, the push strobe from the receive shift register, the host's pop strobe, the error flags carried by the character at the FIFO head, a programmed threshold, and two enable bits. From these it produces the interrupt line, a prioritised identification code and a data-ready status bit.

Three sources compete for the interrupt line. A character with errors at the head of the FIFO ranks highest. An occupancy at or above the programmed threshold ranks next. A timeout request from an external timer ranks lowest. The FIFO storage, the deserializer and the timeout timer live elsewhere. Every output is registered, so the host sees the effect of a change one clock later.

Top module: `rx_irq_ctrl`

## Requirements
- R1: While reset is high and on the first clock after it, `irq` is 0, `irq_id` is 8'hC1 and `data_ready` is 0.
- R2: Unless both `fifo_en` and `rx_irq_en` are 1, `irq` is 0 and `irq_id` is 8'hC1. This holds for any count, error or timeout input.
- R3: With both enables set, no head error, and `fifo_count` at or above the threshold, `irq_id` becomes 8'hC4 and `irq` becomes 1.
- R4: As soon as `fifo_count` drops below the threshold, the data-available code 8'hC4 is withdrawn.
- R5: The 2-bit `trig_sel` picks the threshold: 0 gives 1 entry, 1 gives DEPTH/4, 2 gives DEPTH/2 and 3 gives DEPTH-2. With DEPTH=16 these are 1, 4, 8 and 14.
- R6: With both enables set, a nonzero `head_err` and a nonzero `fifo_count`, `irq_id` becomes 8'hC6 whatever the occupancy or timeout. A nonzero `head_err` with an empty FIFO raises nothing.
- R7: With both enables set and no higher source active, a high `timeout_pend` with a nonzero `fifo_count` gives `irq_id` 8'hCC. An empty FIFO suppresses it.
- R8: `data_ready` becomes 1 on the clock after `push`. It becomes 0 on the clock after `fifo_count` is 0 with no `push`. Otherwise it holds its value.
- R9: All outputs reflect the inputs sampled at the previous rising edge, so the latency is exactly one clock.
- R10: `irq` is 1 exactly when `irq_id` differs from 8'hC1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | FIFO mode enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Threshold select |
| fifo_count | input | CNT_W (5) | Current FIFO occupancy, 0..DEPTH |
| push | input | 1 | Character written into FIFO this cycle |
| pop | input | 1 | Host read from FIFO this cycle |
| head_err | input | ERR_W (3) | Error flags of the head character |
| timeout_pend | input | 1 | Timeout request from external timer |
| irq | output | 1 | Interrupt request |
| irq_id | output | 8 | Interrupt identification code |
| data_ready | output | 1 | Data-ready status bit |

## Verification
The embedded assertions check several rules on every cycle: that `irq` matches `irq_id`, that the disabled state reports idle, that an error at a non-empty head yields C6h, that a push sets `data_ready`, and that the data-available code never appears below the threshold. The bench scenarios are needed for the rest. They show each threshold setting at its exact boundary, the full priority order with several sources active at once, the timeout and error suppression on an empty FIFO, and `data_ready` holding through pops until the FIFO empties.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;
  localparam logic [7:0] ID_NONE    = 8'hC1;
  localparam logic [7:0] ID_LINE    = 8'hC6;
  localparam logic [7:0] ID_AVAIL   = 8'hC4;
  localparam logic [7:0] ID_TIMEOUT = 8'hCC;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_LINE,
    SRC_AVAIL,
    SRC_TIMEOUT
  } irq_src_e;

  function automatic logic [7:0] src_to_id(input irq_src_e s);
    case (s)
      SRC_LINE:    return ID_LINE;
      SRC_AVAIL:   return ID_AVAIL;
      SRC_TIMEOUT: return ID_TIMEOUT;
      default:     return ID_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rx_irq_trig.sv
module rx_irq_trig #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] fifo_count,
  output logic [CNT_W-1:0] level,
  output logic             at_level
);
  localparam int LVL0 = 1;
  localparam int LVL1 = DEPTH / 4;
  localparam int LVL2 = DEPTH / 2;
  localparam int LVL3 = DEPTH - 2;

  logic [CNT_W-1:0] lvl_tab [4];

  generate
    for (genvar i = 0; i < 4; i++) begin : g_lvl
      localparam int V = (i == 0) ? LVL0 : (i == 1) ? LVL1 : (i == 2) ? LVL2 : LVL3;
      assign lvl_tab[i] = CNT_W'(V);
    end
  endgenerate

  always_comb begin
    level    = lvl_tab[trig_sel];
    at_level = (fifo_count >= level);
  end
endmodule

// File: rtl/rx_irq_prio.sv
module rx_irq_prio
  import rx_irq_pkg::*;
#(
  parameter int ERR_W = 3
) (
  input  logic             active,
  input  logic             not_empty,
  input  logic [ERR_W-1:0] head_err,
  input  logic             at_level,
  input  logic             timeout_pend,
  output irq_src_e         src
);
  always_comb begin
    src = SRC_NONE;
    if (active) begin
      if (not_empty && (|head_err))      src = SRC_LINE;
      else if (at_level)                 src = SRC_AVAIL;
      else if (not_empty && timeout_pend) src = SRC_TIMEOUT;
    end
  end
endmodule

// File: rtl/rx_irq_ready.sv
module rx_irq_ready #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             ready
);
  always_ff @(posedge clk) begin
    if (rst)                   ready <= 1'b0;
    else if (push)             ready <= 1'b1;
    else if (fifo_count == '0) ready <= 1'b0;
  end

  assert_dr_push_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(push)) |-> ready);
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
  import rx_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ERR_W = 3,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_en,
  input  logic             rx_irq_en,
  input  logic [1:0]       trig_sel,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             push,
  input  logic             pop,
  input  logic [ERR_W-1:0] head_err,
  input  logic             timeout_pend,
  output logic             irq,
  output logic [7:0]       irq_id,
  output logic             data_ready
);
  logic             active;
  logic             not_empty;
  logic [CNT_W-1:0] level;
  logic             at_level;
  irq_src_e         src;

  // pop only matters through the count it changes
  logic unused_pop;
  assign unused_pop = pop;

  assign active    = fifo_en & rx_irq_en;
  assign not_empty = (fifo_count != '0);

  rx_irq_trig #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_trig (
    .trig_sel  (trig_sel),
    .fifo_count(fifo_count),
    .level     (level),
    .at_level  (at_level)
  );

  rx_irq_prio #(.ERR_W(ERR_W)) u_prio (
    .active      (active),
    .not_empty   (not_empty),
    .head_err    (head_err),
    .at_level    (at_level),
    .timeout_pend(timeout_pend),
    .src         (src)
  );

  rx_irq_ready #(.CNT_W(CNT_W)) u_ready (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .fifo_count(fifo_count),
    .ready     (data_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq    <= 1'b0;
      irq_id <= ID_NONE;
    end else begin
      irq    <= (src != SRC_NONE);
      irq_id <= src_to_id(src);
    end
  end

  assert_irq_matches_id_R10: assert property (@(posedge clk) disable iff (rst)
    irq == (irq_id != ID_NONE));

  assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fifo_en && rx_irq_en)) |-> (irq_id == ID_NONE && !irq));

  assert_line_first_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fifo_en && rx_irq_en && (fifo_count != '0) && (|head_err)))
      |-> (irq_id == ID_LINE));

  assert_no_avail_below_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fifo_count < level)) |-> (irq_id != ID_AVAIL));
endmodule

// File: tb/rx_irq_ctrl_tb.sv
module rx_irq_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int ERR_W = 3;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic fifo_en = 0, rx_irq_en = 0, push = 0, pop = 0, timeout_pend = 0;
  logic [1:0] trig_sel = 0;
  logic [CNT_W-1:0] fifo_count = 0;
  logic [ERR_W-1:0] head_err = 0;
  logic irq, data_ready;
  logic [7:0] irq_id;

  int n_cmp = 0, n_bad = 0;
  logic dr_m = 0;

  typedef struct {
    logic       irq;
    logic [7:0] id;
    logic       dr;
    string      req;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  rx_irq_ctrl #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u_dut (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_irq_en(rx_irq_en),
    .trig_sel(trig_sel), .fifo_count(fifo_count), .push(push), .pop(pop),
    .head_err(head_err), .timeout_pend(timeout_pend),
    .irq(irq), .irq_id(irq_id), .data_ready(data_ready)
  );

  function automatic int lvl_of(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(input string req, input logic fe, input logic ie,
                      input logic [1:0] ts, input int cnt, input logic pu,
                      input logic po, input logic [ERR_W-1:0] er, input logic to);
    exp_t e;
    logic act;
    @(negedge clk);
    fifo_en = fe; rx_irq_en = ie; trig_sel = ts; fifo_count = CNT_W'(cnt);
    push = pu; pop = po; head_err = er; timeout_pend = to;
    act = fe & ie;
    e.id = 8'hC1;
    if (act) begin
      if (cnt != 0 && er != 0)       e.id = 8'hC6;
      else if (cnt >= lvl_of(ts))    e.id = 8'hC4;
      else if (cnt != 0 && to)       e.id = 8'hCC;
    end
    e.irq = (e.id != 8'hC1);
    if (pu) dr_m = 1;
    else if (cnt == 0) dr_m = 0;
    e.dr = dr_m;
    e.req = req;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.req, " id"}, irq_id, e.id);
      chk({e.req, " irq (R10)"}, {7'd0, irq}, {7'd0, e.irq});
      chk({e.req, " data_ready"}, {7'd0, data_ready}, {7'd0, e.dr});
    end
  end

  initial begin
    #200000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset id", irq_id, 8'hC1);
    chk("R1 reset irq", {7'd0, irq}, 8'd0);
    chk("R1 reset dr", {7'd0, data_ready}, 8'd0);
    rst = 0;
    // R2: disabled, everything active on inputs
    step("R2", 0, 1, 0, 5, 1, 0, 3'b001, 1);
    step("R2", 1, 0, 0, 5, 0, 0, 3'b010, 1);
    step("R2", 0, 0, 0, 0, 0, 0, 3'b000, 0);
    // R8 data_ready set on push, hold through pops, clear when empty
    step("R8", 0, 0, 0, 1, 1, 0, 0, 0);
    step("R8", 0, 0, 0, 2, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    // R5/R3/R4: every threshold at its boundary
    for (int s = 0; s < 4; s++) begin
      int l = lvl_of(2'(s));
      step("R5 below", 1, 1, 2'(s), l - 1, 0, 0, 0, 0);
      step("R3 at",    1, 1, 2'(s), l,     1, 0, 0, 0);
      step("R3 above", 1, 1, 2'(s), (l < DEPTH) ? l + 1 : l, 0, 0, 0, 0);
      step("R4 drop",  1, 1, 2'(s), l - 1, 0, 1, 0, 0);
    end
    // R6 priority over data-available and timeout
    step("R6", 1, 1, 3, 15, 0, 0, 3'b100, 1);
    step("R6", 1, 1, 0, 1,  0, 0, 3'b010, 0);
    step("R6 empty", 1, 1, 0, 0, 0, 0, 3'b111, 1);
    // R7 timeout lowest, suppressed when empty
    step("R7", 1, 1, 3, 3, 0, 0, 0, 1);
    step("R7 under avail", 1, 1, 1, 4, 0, 0, 0, 1);
    step("R7 empty", 1, 1, 3, 0, 0, 0, 0, 1);
    // R9 single-cycle latency back-to-back toggles
    step("R9", 1, 1, 2, 8, 0, 0, 0, 0);
    step("R9", 1, 1, 2, 7, 0, 0, 0, 0);
    step("R9", 1, 1, 2, 8, 0, 0, 0, 0);
    step("R9", 0, 1, 2, 8, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule